// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Acknowledge

This block collects a parameterised vector of interrupt lines for a single processor and decides which one is presented on one interrupt request line. A distributor half keeps per-line state: enable, pending, active, an eight-bit priority and a trigger mode (edge or level). A processor-facing half applies a priority mask and a binary-point split of the priority, used to decide whether a new interrupt may preempt the one being handled.

Software reaches the block through a single-cycle register port. Read data is combinational in the cycle of the request, and side effects take place at the clock edge that ends the request. An acknowledge read hands out the best qualifying interrupt and marks it active. An end-of-interrupt write of that interrupt's ID retires it. Lower priority values are more urgent, and equal values go to the lower ID.

Top module: `intc_top`

Register map (byte addresses, 32-bit data):

| Address | Access | Meaning |
|---|---|---|
| 0x000 | read/write | bit 0 enables signalling to the processor |
| 0x004 | read/write | priority mask, 8 bits |
| 0x008 | read/write | binary point, 3 bits |
| 0x00C | read | acknowledge; returns an ID, or 1023 when nothing qualifies |
| 0x010 | write | end of interrupt; write the ID |
| 0x014 | read | running priority |
| 0x018 | read | highest pending ID |
| 0x100 | read/write | bit 0 enables forwarding by the distributor |
| 0x104 / 0x108 | write / read | set-enable and clear-enable; both read the enables |
| 0x10C / 0x110 | write / read | set-pending and clear-pending; both read the pending bits |
| 0x114 | read | active bits |
| 0x118 | read/write | trigger mode bits |
| 0x200 + 4·n | read/write | priority of line n |
| 0x300 + 4·n | read | status of line n |

## Requirements
- R1: Writing 1s to 0x104 sets the matching enable bits, and writing 1s to 0x108 clears them. Bits written 0 are unchanged. Both addresses read the enable vector.
- R2: Writing 1s to 0x10C forces the matching pending bits, and writing 1s to 0x110 removes them. Both addresses read the effective pending vector.
- R3: Trigger bit n at 0x118 set to 1 selects edge mode for line n: a rising edge latches pending, and pending stays latched after the line falls. Set to 0 it selects level mode, in which pending follows the line while the line is high.
- R4: While bit 0 of 0x100 is 0, no interrupt is forwarded: the highest pending register reads 1023 and the request line is low. While bit 0 of 0x000 is 0, the request line is low and acknowledge returns 1023.
- R5: An acknowledge read returns the ID of the enabled, pending, non-active interrupt with the lowest priority value, with ties going to the lowest ID. At the end of that read the interrupt becomes active and its latched pending is cleared.
- R6: When nothing qualifies, an acknowledge read returns 1023 and changes no pending or active state.
- R7: Writing an ID to 0x010 clears that interrupt's active bit. An ID of NUM_IRQ or above has no effect.
- R8: An interrupt qualifies only if its priority value is strictly below the mask at 0x004.
- R9: While an interrupt is active, another one qualifies only if its group priority is strictly below the running group. With binary point b, the group is priority bits [7:b+1].
- R10: The running priority at 0x014 is the lowest priority value among active interrupts, or 0xFF when none is active. The status of line n reads bit 1 as active and bit 0 as pending: 0 inactive, 1 pending, 2 active, 3 both.
- R11: 0x018 returns the ID that R5 would select, ignoring the mask, the preemption rule and the interface enable, or 1023 if there is none.
- R12: After reset every enable, pending, active and trigger bit is 0, every priority is 0, the mask is 0, the binary point is 0, both enables are off, and the request line is low.
- R13: The request line is high exactly when an acknowledge read would return a real ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | asynchronous reset, active low |
| irqLines | input | NUM_IRQ | interrupt source lines |
| regAddr | input | 12 | register byte address |
| regWr | input | 1 | write request for this cycle |
| regRd | input | 1 | read request for this cycle |
| regWdata | input | 32 | write data |
| regRdata | output | 32 | read data, valid in the cycle of the request |
| irqOut | output | 1 | interrupt request to the processor |

## Verification
Read data, including the ID returned by acknowledge, is due in the same cycle as the request. The bench samples it one nanosecond after driving the request, before the edge that commits it. Effects of a write or an acknowledge on pending, active, running priority and the request line appear just after that edge, so the request line is sampled one nanosecond after it. An edge-mode line latches pending at the first edge that sees it high, while a level-mode line is seen at once. The bench drives the lines half a cycle ahead and reads state only after at least one edge has passed.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL  = 12'h000;
  localparam logic [ADDR_W-1:0] A_MASK  = 12'h004;
  localparam logic [ADDR_W-1:0] A_BPT   = 12'h008;
  localparam logic [ADDR_W-1:0] A_ACK   = 12'h00C;
  localparam logic [ADDR_W-1:0] A_EOI   = 12'h010;
  localparam logic [ADDR_W-1:0] A_RUN   = 12'h014;
  localparam logic [ADDR_W-1:0] A_HPEND = 12'h018;
  localparam logic [ADDR_W-1:0] A_DIST  = 12'h100;
  localparam logic [ADDR_W-1:0] A_SETEN = 12'h104;
  localparam logic [ADDR_W-1:0] A_CLREN = 12'h108;
  localparam logic [ADDR_W-1:0] A_SETPD = 12'h10C;
  localparam logic [ADDR_W-1:0] A_CLRPD = 12'h110;
  localparam logic [ADDR_W-1:0] A_ACTV  = 12'h114;
  localparam logic [ADDR_W-1:0] A_TRIG  = 12'h118;
  localparam logic [3:0] WIN_PRIO = 4'h2;
  localparam logic [3:0] WIN_STAT = 4'h3;

  // strobes from control to datapath, one register operation per cycle
  typedef struct packed {
    logic setEn;
    logic clrEn;
    logic setPend;
    logic clrPend;
    logic wrCfg;
    logic wrPrio;
    logic ack;
    logic eoi;
    logic [4:0] idx;
    logic [DATA_W-1:0] data;
  } strobe_t;
endpackage

// File: rtl/intc_dp.sv
module intc_dp
  import intc_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 8,
  parameter int ID_W    = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_IRQ-1:0]   irqLines,
  input  logic                 distEn,
  input  strobe_t              str,
  output logic                 hpValid,
  output logic [ID_W-1:0]      hpId,
  output logic [PRIO_W-1:0]    hpPrio,
  output logic [PRIO_W-1:0]    runPrio,
  output logic                 anyActive,
  output logic [NUM_IRQ-1:0]   enBits,
  output logic [NUM_IRQ-1:0]   pendBits,
  output logic [NUM_IRQ-1:0]   actBits,
  output logic [NUM_IRQ-1:0]   cfgBits,
  output logic [PRIO_W-1:0]    prioArr [NUM_IRQ]
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam logic [PRIO_W-1:0] IDLE_PRIO = '1;
  localparam logic [ID_W-1:0] SPURIOUS = ID_W'(1023);

  logic [NUM_IRQ-1:0] latchQ, latchN, activeQ, activeN, lineQ, rise;
  logic [NUM_IRQ-1:0] wMask;
  logic [ID_W-1:0]    eoiId;
  logic [IDX_W-1:0]   hpIdx;
  logic               unusedBits;

  assign wMask    = str.data[NUM_IRQ-1:0];
  assign eoiId    = str.data[ID_W-1:0];
  assign rise     = irqLines & ~lineQ;
  assign pendBits = latchQ | (~cfgBits & irqLines);
  assign actBits  = activeQ;
  assign hpIdx    = hpId[IDX_W-1:0];
  assign unusedBits = ^{str.data, str.idx};

  // arbitration: lowest value wins, strict compare keeps the lowest ID on ties
  always_comb begin
    hpValid = 1'b0;
    hpId    = SPURIOUS;
    hpPrio  = IDLE_PRIO;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (distEn && enBits[i] && pendBits[i] && !activeQ[i] &&
          (!hpValid || prioArr[i] < hpPrio)) begin
        hpValid = 1'b1;
        hpId    = ID_W'(i);
        hpPrio  = prioArr[i];
      end
    end
  end

  always_comb begin
    runPrio = IDLE_PRIO;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (activeQ[i] && prioArr[i] < runPrio) runPrio = prioArr[i];
    end
  end
  assign anyActive = |activeQ;

  always_comb begin
    latchN = latchQ | (cfgBits & rise);
    if (str.setPend) latchN = latchN | wMask;
    if (str.clrPend) latchN = latchN & ~wMask;
    if (str.ack)     latchN[hpIdx] = 1'b0;
    activeN = activeQ;
    if (str.ack) activeN[hpIdx] = 1'b1;
    if (str.eoi && int'(eoiId) < NUM_IRQ) activeN[eoiId[IDX_W-1:0]] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBits  <= '0;
      cfgBits <= '0;
      latchQ  <= '0;
      activeQ <= '0;
      lineQ   <= '0;
    end else begin
      lineQ   <= irqLines;
      latchQ  <= latchN;
      activeQ <= activeN;
      if (str.setEn) enBits <= enBits | wMask;
      else if (str.clrEn) enBits <= enBits & ~wMask;
      if (str.wrCfg) cfgBits <= wMask;
    end
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : gPrio
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prioArr[g] <= '0;
      else if (str.wrPrio && str.idx[IDX_W-1:0] == IDX_W'(g))
        prioArr[g] <= str.data[PRIO_W-1:0];
    end
  end

  // R5
  ack_to_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.ack |=> activeQ[$past(hpIdx)]);
  // R6
  no_silent_activate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !str.ack |=> ((activeQ & ~$past(activeQ)) == '0));
  // R7
  eoi_retire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (str.eoi && int'(eoiId) < NUM_IRQ) |=> !activeQ[$past(eoiId[IDX_W-1:0])]);
  // R2
  clear_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.clrPend |=> ((latchQ & $past(wMask)) == '0));
  // R10
  running_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !anyActive |-> runPrio == IDLE_PRIO);
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 8,
  parameter int BP_W    = 3,
  parameter int ID_W    = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWr,
  input  logic                 regRd,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    regRdata,
  output logic                 irqOut,
  output logic                 distEn,
  output strobe_t              str,
  input  logic                 hpValid,
  input  logic [ID_W-1:0]      hpId,
  input  logic [PRIO_W-1:0]    hpPrio,
  input  logic [PRIO_W-1:0]    runPrio,
  input  logic                 anyActive,
  input  logic [NUM_IRQ-1:0]   enBits,
  input  logic [NUM_IRQ-1:0]   pendBits,
  input  logic [NUM_IRQ-1:0]   actBits,
  input  logic [NUM_IRQ-1:0]   cfgBits,
  input  logic [PRIO_W-1:0]    prioArr [NUM_IRQ]
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam logic [ID_W-1:0] SPURIOUS = ID_W'(1023);

  logic              ifEn;
  logic [PRIO_W-1:0] maskQ, gmask;
  logic [BP_W-1:0]   bpQ;
  logic [PRIO_W:0]   gwide;
  logic [4:0]        winIdx;
  logic              winOk, prioWin, statWin, qualify, unusedCtrl;
  logic [IDX_W-1:0]  sel;

  assign winIdx  = regAddr[6:2];
  assign sel     = winIdx[IDX_W-1:0];
  assign winOk   = !regAddr[7] && (regAddr[1:0] == 2'b00) && (int'(winIdx) < NUM_IRQ);
  assign prioWin = (regAddr[ADDR_W-1:8] == WIN_PRIO) && winOk;
  assign statWin = (regAddr[ADDR_W-1:8] == WIN_STAT) && winOk;
  assign unusedCtrl = ^winIdx;

  // group field is priority bits above the binary point
  assign gwide = {(PRIO_W+1){1'b1}} << (int'(bpQ) + 1);
  assign gmask = gwide[PRIO_W-1:0];

  assign qualify = ifEn && hpValid && (hpPrio < maskQ) &&
                   (!anyActive || ((hpPrio & gmask) < (runPrio & gmask)));
  assign irqOut  = qualify;

  always_comb begin
    str         = '0;
    str.data    = regWdata;
    str.idx     = winIdx;
    str.setEn   = regWr && regAddr == A_SETEN;
    str.clrEn   = regWr && regAddr == A_CLREN;
    str.setPend = regWr && regAddr == A_SETPD;
    str.clrPend = regWr && regAddr == A_CLRPD;
    str.wrCfg   = regWr && regAddr == A_TRIG;
    str.wrPrio  = regWr && prioWin;
    str.eoi     = regWr && regAddr == A_EOI;
    str.ack     = regRd && regAddr == A_ACK && qualify;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ifEn   <= 1'b0;
      distEn <= 1'b0;
      maskQ  <= '0;
      bpQ    <= '0;
    end else if (regWr) begin
      if (regAddr == A_CTRL) ifEn   <= regWdata[0];
      if (regAddr == A_DIST) distEn <= regWdata[0];
      if (regAddr == A_MASK) maskQ  <= regWdata[PRIO_W-1:0];
      if (regAddr == A_BPT)  bpQ    <= regWdata[BP_W-1:0];
    end
  end

  always_comb begin
    regRdata = '0;
    if (regRd) begin
      case (regAddr)
        A_CTRL:  regRdata = DATA_W'(ifEn);
        A_MASK:  regRdata = DATA_W'(maskQ);
        A_BPT:   regRdata = DATA_W'(bpQ);
        A_ACK:   regRdata = DATA_W'(qualify ? hpId : SPURIOUS);
        A_RUN:   regRdata = DATA_W'(runPrio);
        A_HPEND: regRdata = DATA_W'(hpId);
        A_DIST:  regRdata = DATA_W'(distEn);
        A_SETEN, A_CLREN: regRdata = DATA_W'(enBits);
        A_SETPD, A_CLRPD: regRdata = DATA_W'(pendBits);
        A_ACTV:  regRdata = DATA_W'(actBits);
        A_TRIG:  regRdata = DATA_W'(cfgBits);
        default: begin
          if (prioWin) regRdata = DATA_W'(prioArr[sel]);
          else if (statWin) regRdata = DATA_W'({actBits[sel], pendBits[sel]});
        end
      endcase
    end
  end

  // R4
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ifEn || !distEn) |-> !irqOut);
  // R8
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> hpPrio < maskQ);
  // R9
  preempt_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && anyActive) |-> (hpPrio & gmask) < (runPrio & gmask));
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 8,
  parameter int BP_W    = 3,
  parameter int ID_W    = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_IRQ-1:0]   irqLines,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWr,
  input  logic                 regRd,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    regRdata,
  output logic                 irqOut
);
  strobe_t            str;
  logic               distEn, hpValid, anyActive;
  logic [ID_W-1:0]    hpId;
  logic [PRIO_W-1:0]  hpPrio, runPrio;
  logic [NUM_IRQ-1:0] enBits, pendBits, actBits, cfgBits;
  logic [PRIO_W-1:0]  prioArr [NUM_IRQ];

  intc_ctrl #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .BP_W(BP_W), .ID_W(ID_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut), .distEn(distEn),
    .str(str), .hpValid(hpValid), .hpId(hpId), .hpPrio(hpPrio), .runPrio(runPrio),
    .anyActive(anyActive), .enBits(enBits), .pendBits(pendBits), .actBits(actBits),
    .cfgBits(cfgBits), .prioArr(prioArr));

  intc_dp #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W)) i_dp (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .distEn(distEn), .str(str),
    .hpValid(hpValid), .hpId(hpId), .hpPrio(hpPrio), .runPrio(runPrio),
    .anyActive(anyActive), .enBits(enBits), .pendBits(pendBits), .actBits(actBits),
    .cfgBits(cfgBits), .prioArr(prioArr));
endmodule

// File: tb/test_intc_top.sv
module test_intc_top;
  localparam int N = 8;
  localparam int NV = 64;

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;   // write data, or expected read data
    logic [1:0]  irqChk; // 0 none, 2 expect low, 3 expect high
    logic [3:0]  req;
  } vec_t;

  function automatic vec_t mkW(logic [11:0] a, logic [31:0] d, logic [1:0] ic, logic [3:0] r);
    return '{wr: 1'b1, addr: a, data: d, irqChk: ic, req: r};
  endfunction
  function automatic vec_t mkR(logic [11:0] a, logic [31:0] e, logic [1:0] ic, logic [3:0] r);
    return '{wr: 1'b0, addr: a, data: e, irqChk: ic, req: r};
  endfunction

  localparam vec_t TBL [NV] = '{
    mkW(12'h100, 32'h1, 2'd2, 4'd4),      // R4 distributor on, interface off
    mkW(12'h000, 32'h1, 2'd2, 4'd4),
    mkW(12'h004, 32'hF0, 2'd0, 4'd8),
    mkW(12'h20C, 32'h40, 2'd0, 4'd5),
    mkW(12'h214, 32'h40, 2'd0, 4'd5),
    mkW(12'h204, 32'h80, 2'd0, 4'd5),
    mkW(12'h104, 32'h2A, 2'd2, 4'd1),     // R1 set-enable
    mkR(12'h104, 32'h2A, 2'd0, 4'd1),
    mkW(12'h108, 32'h20, 2'd0, 4'd1),     // R1 clear-enable one bit
    mkR(12'h108, 32'h0A, 2'd0, 4'd1),
    mkW(12'h104, 32'h20, 2'd0, 4'd1),
    mkR(12'h104, 32'h2A, 2'd0, 4'd1),
    mkR(12'h018, 32'h3FF, 2'd2, 4'd11),   // R11 nothing pending
    mkW(12'h10C, 32'h2A, 2'd3, 4'd13),    // R13 request rises
    mkR(12'h10C, 32'h2A, 2'd0, 4'd2),     // R2
    mkR(12'h018, 32'h3, 2'd0, 4'd11),     // R11 tie goes to lower ID
    mkR(12'h00C, 32'h3, 2'd2, 4'd5),      // R5 acknowledge
    mkR(12'h30C, 32'h2, 2'd0, 4'd10),     // R10 status active
    mkR(12'h014, 32'h40, 2'd0, 4'd10),
    mkR(12'h00C, 32'h3FF, 2'd0, 4'd9),    // R9 equal group does not preempt
    mkR(12'h314, 32'h1, 2'd0, 4'd6),      // R6 state unchanged
    mkW(12'h010, 32'h3, 2'd3, 4'd7),      // R7
    mkR(12'h014, 32'hFF, 2'd0, 4'd10),
    mkR(12'h00C, 32'h5, 2'd0, 4'd5),
    mkR(12'h00C, 32'h3FF, 2'd0, 4'd9),
    mkW(12'h010, 32'h5, 2'd3, 4'd7),
    mkR(12'h00C, 32'h1, 2'd0, 4'd5),
    mkW(12'h010, 32'h1, 2'd2, 4'd7),
    mkR(12'h10C, 32'h0, 2'd0, 4'd5),      // R5 pending removed by ack
    mkW(12'h204, 32'hF0, 2'd0, 4'd8),     // R8 priority equal to mask
    mkW(12'h10C, 32'h02, 2'd2, 4'd8),
    mkR(12'h00C, 32'h3FF, 2'd0, 4'd8),
    mkR(12'h304, 32'h1, 2'd0, 4'd6),
    mkW(12'h004, 32'hF1, 2'd3, 4'd8),
    mkW(12'h110, 32'h02, 2'd2, 4'd2),
    mkR(12'h304, 32'h0, 2'd0, 4'd2),
    mkW(12'h214, 32'h42, 2'd0, 4'd9),     // R9 binary point 0
    mkW(12'h10C, 32'h20, 2'd0, 4'd9),
    mkR(12'h00C, 32'h5, 2'd0, 4'd9),
    mkW(12'h10C, 32'h08, 2'd3, 4'd9),
    mkR(12'h00C, 32'h3, 2'd0, 4'd9),
    mkR(12'h014, 32'h40, 2'd0, 4'd10),
    mkR(12'h114, 32'h28, 2'd0, 4'd5),
    mkW(12'h010, 32'h3, 2'd0, 4'd7),
    mkR(12'h014, 32'h42, 2'd0, 4'd10),
    mkW(12'h010, 32'h5, 2'd0, 4'd7),
    mkW(12'h008, 32'h2, 2'd0, 4'd9),      // R9 binary point 2
    mkW(12'h10C, 32'h20, 2'd0, 4'd9),
    mkR(12'h00C, 32'h5, 2'd0, 4'd9),
    mkW(12'h10C, 32'h08, 2'd2, 4'd9),
    mkR(12'h00C, 32'h3FF, 2'd0, 4'd9),
    mkW(12'h010, 32'h5, 2'd3, 4'd7),
    mkR(12'h00C, 32'h3, 2'd0, 4'd5),
    mkW(12'h010, 32'h3, 2'd2, 4'd7),
    mkW(12'h10C, 32'h08, 2'd3, 4'd4),     // R4 gating
    mkW(12'h000, 32'h0, 2'd2, 4'd4),
    mkR(12'h00C, 32'h3FF, 2'd0, 4'd4),
    mkW(12'h000, 32'h1, 2'd3, 4'd4),
    mkW(12'h100, 32'h0, 2'd2, 4'd4),
    mkR(12'h018, 32'h3FF, 2'd0, 4'd4),
    mkW(12'h100, 32'h1, 2'd3, 4'd4),
    mkW(12'h110, 32'h08, 2'd2, 4'd2),
    mkW(12'h010, 32'h3FF, 2'd0, 4'd7),    // R7 out-of-range ID ignored
    mkR(12'h114, 32'h0, 2'd0, 4'd7)
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic [N-1:0] irqLines = '0;
  logic [11:0] regAddr = '0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic irqOut;
  int checks = 0, errors = 0;
  logic [31:0] rdv;

  always #5 clk = ~clk;

  intc_top #(.NUM_IRQ(N)) i_intc_top (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .regAddr(regAddr), .regWr(regWr),
    .regRd(regRd), .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one bus operation; read data sampled before the committing edge
  task automatic busOp(logic wr, logic [11:0] a, logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    regAddr = a; regWr = wr; regRd = !wr; regWdata = wr ? d : '0;
    #1 rd = regRdata;
    @(posedge clk);
    #1 regWr = 1'b0; regRd = 1'b0;
  endtask

  task automatic wrReg(logic [11:0] a, logic [31:0] d);
    busOp(1'b1, a, d, rdv);
  endtask

  task automatic rdChk(string tag, logic [11:0] a, logic [31:0] exp);
    busOp(1'b0, a, 32'h0, rdv);
    check(tag, rdv, exp);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual 0x0 expected 0x1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R12 irq after reset", 32'(irqOut), 32'h0);
    @(negedge clk) rstN = 1'b1;
    rdChk("R12 running priority idle", 12'h014, 32'hFF);
    rdChk("R12 mask", 12'h004, 32'h0);
    rdChk("R12 enables", 12'h104, 32'h0);
    rdChk("R12 trigger", 12'h118, 32'h0);
    rdChk("R12 acknowledge spurious", 12'h00C, 32'h3FF);

    for (int k = 0; k < NV; k++) begin
      busOp(TBL[k].wr, TBL[k].addr, TBL[k].data, rdv);
      if (!TBL[k].wr)
        check($sformatf("R%0d vector %0d read", TBL[k].req, k), rdv, TBL[k].data);
      if (TBL[k].irqChk[1])
        check($sformatf("R%0d vector %0d irq", TBL[k].req, k), 32'(irqOut), 32'(TBL[k].irqChk[0]));
    end

    // R3 level mode follows the line
    wrReg(12'h200, 32'h10);
    wrReg(12'h104, 32'h01);
    @(negedge clk) irqLines[0] = 1'b1;
    rdChk("R3 level pending", 12'h300, 32'h1);
    @(negedge clk) irqLines[0] = 1'b0;
    rdChk("R3 level released", 12'h300, 32'h0);
    // R3 edge mode latches a pulse
    wrReg(12'h118, 32'h01);
    rdChk("R3 trigger readback", 12'h118, 32'h1);
    @(negedge clk) irqLines[0] = 1'b1;
    @(negedge clk) irqLines[0] = 1'b0;
    rdChk("R3 edge latched", 12'h300, 32'h1);
    #1 check("R13 irq for edge", 32'(irqOut), 32'h1);
    rdChk("R5 ack edge line", 12'h00C, 32'h0);
    rdChk("R10 edge status active", 12'h300, 32'h2);
    wrReg(12'h010, 32'h0);
    // R10 level line held high through acknowledge
    wrReg(12'h118, 32'h00);
    @(negedge clk) irqLines[0] = 1'b1;
    rdChk("R5 ack level line", 12'h00C, 32'h0);
    rdChk("R10 status pending and active", 12'h300, 32'h3);
    @(negedge clk) irqLines[0] = 1'b0;
    rdChk("R10 status active only", 12'h300, 32'h2);
    wrReg(12'h010, 32'h0);
    rdChk("R7 status after retire", 12'h300, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule